// File: doc/BRIEF.md
# Latent-to-Sample Decoder Engine

This block runs inference for a very small generative decoder in fixed point. A four-element latent vector goes in; eight output samples come out. Three layers run in order on one time-shared multiplier. First a dense 4x4 layer with bias, whose results are rectified (negatives become zero). Second, a single-channel transposed 1D convolution with four taps, stride 2 and padding 1, which turns four values into eight. Third, a single-channel pointwise layer that scales and offsets each sample. Every weight and bias is a parameter fixed when the block is built.

A caller presents the latent vector and pulses `start` while the engine is idle. The vector is captured on that edge. The engine then spends 16 cycles on the dense layer, 16 on the transposed convolution and 8 on the pointwise layer. It then raises `done` for a single cycle. The eight outputs stay on `samplesOut` until the pointwise phase of the next run overwrites them.

All values use signed 16-bit Q8.8 format. Sums are carried at 36 bits. Each layer result is rounded by adding 128 and shifting right arithmetically by 8, then clamped to the range -32768..32767.

Top module: `lat2sig_decoder`

## Requirements
- R1: While reset is held and right after it, `busy` and `done` are 0 and `samplesOut` is all zero.
- R2: A `start` pulse while `busy` is 0 captures `latentIn` on that edge. Later changes to `latentIn` during the run do not affect the result. Element e sits in bits [16e+15:16e], and output sample n sits in bits [16n+15:16n].
- R3: Dense layer: hidden j = clamp(round(sum over i of W[4j+i]*x[i] + (B[j]<<8))). Rounding is add 128, then arithmetic shift right by 8.
- R4: Any negative hidden value becomes 0. An all-zero latent with non-positive dense biases therefore gives eight identical outputs, computed from the convolution bias alone.
- R5: In the transposed convolution, hidden i times tap k is added to position 2i+k-1. Only positions 0..7 are kept. Every position starts at the convolution bias shifted left by 8.
- R6: Pointwise layer: out n = clamp(round(s*PW_W + (PW_B<<8))), where s = clamp(round(position n of the convolution sum)).
- R7: Every rounded layer result clamps to 32767 when above it and to -32768 when below it.
- R8: `done` is high for exactly one cycle. Counting the accepting edge as edge 1, it is visible after the 41st rising edge.
- R9: A `start` pulse while `busy` is 1 has no effect on the result or on the timing of the current run.
- R10: The convolution sums are cleared at each accepted start. A run's result does not depend on earlier runs.
- R11: `samplesOut` holds its value while the engine is idle and `start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an inference when idle |
| latentIn | input | 64 | Four Q8.8 latent elements |
| busy | output | 1 | High from accepted start through the done cycle |
| done | output | 1 | One-cycle pulse when outputs are valid |
| samplesOut | output | 128 | Eight Q8.8 output samples |

## Verification
A wrong accumulator, a misplaced scatter position or a missing clear shows up as a wrong value in at least one of the eight samples. It appears in the same run, 41 cycles after start, so every run is compared against a reference model. A fault in the sequencer instead shifts or repeats the `done` pulse, which the latency count catches within one run. Faults in rectification or clamping only show for particular inputs, so the stimulus includes zero, full-scale positive and full-scale negative latents next to random ones.

// File: rtl/lat2sig_pkg.sv
package lat2sig_pkg;
  localparam int DW    = 16;
  localparam int FRAC  = 8;
  localparam int NIN   = 4;
  localparam int KLEN  = 4;
  localparam int NOUT  = 2 * NIN;
  localparam int ACCW  = 36;
  localparam int CNTW  = 4;

  typedef enum logic [2:0] {S_IDLE, S_FC, S_DECONV, S_PW, S_DONE} state_e;

  typedef struct packed {
    logic            capture;
    logic            fcStep;
    logic            dcStep;
    logic            pwStep;
    logic [CNTW-1:0] idx;
  } ctrl_t;

  localparam logic signed [ACCW-1:0] HALF_LSB = ACCW'(1) <<< (FRAC - 1);
  localparam logic signed [ACCW-1:0] POS_LIM  = (ACCW'(1) <<< (DW - 1)) - ACCW'(1);
  localparam logic signed [ACCW-1:0] NEG_LIM  = -(ACCW'(1) <<< (DW - 1));

  function automatic logic signed [DW-1:0] rndSat(input logic signed [ACCW-1:0] a);
    logic signed [ACCW-1:0] t;
    t = (a + HALF_LSB) >>> FRAC;
    if (t > POS_LIM) return POS_LIM[DW-1:0];
    if (t < NEG_LIM) return NEG_LIM[DW-1:0];
    return t[DW-1:0];
  endfunction
endpackage

// File: rtl/lat2sig_ctrl.sv
module lat2sig_ctrl import lat2sig_pkg::*; (
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  output ctrl_t ctrl,
  output logic  busy,
  output logic  done
);
  localparam int FC_STEPS = NIN * NIN;
  localparam int DC_STEPS = NIN * KLEN;
  localparam int PW_STEPS = NOUT;

  state_e state;
  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin state <= S_FC; cnt <= '0; end
        S_FC:
          if (cnt == CNTW'(FC_STEPS - 1)) begin state <= S_DECONV; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        S_DECONV:
          if (cnt == CNTW'(DC_STEPS - 1)) begin state <= S_PW; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        S_PW:
          if (cnt == CNTW'(PW_STEPS - 1)) begin state <= S_DONE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.capture = (state == S_IDLE) && start;
    ctrl.fcStep  = (state == S_FC);
    ctrl.dcStep  = (state == S_DECONV);
    ctrl.pwStep  = (state == S_PW);
    ctrl.idx     = cnt;
    busy         = (state != S_IDLE);
    done         = (state == S_DONE);
  end
endmodule

// File: rtl/lat2sig_dp.sv
module lat2sig_dp import lat2sig_pkg::*; #(
  parameter logic signed [DW-1:0] FC_W [NIN*NIN] = '{default: '0},
  parameter logic signed [DW-1:0] FC_B [NIN]     = '{default: '0},
  parameter logic signed [DW-1:0] DC_W [KLEN]    = '{default: '0},
  parameter logic signed [DW-1:0] DC_B           = '0,
  parameter logic signed [DW-1:0] PW_W           = '0,
  parameter logic signed [DW-1:0] PW_B           = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_t              ctrl,
  input  logic [NIN*DW-1:0]  latentIn,
  output logic [NOUT*DW-1:0] samplesOut,
  output logic [NIN*DW-1:0]  hiddenFlat
);
  localparam int IW = $clog2(NIN);
  localparam int KW = $clog2(KLEN);
  localparam int OW = $clog2(NOUT);
  localparam int PPW = OW + 2;

  logic signed [DW-1:0]   lat  [NIN];
  logic signed [DW-1:0]   hid  [NIN];
  logic signed [ACCW-1:0] dacc [NOUT];
  logic signed [DW-1:0]   outR [NOUT];
  logic signed [ACCW-1:0] acc;

  logic [IW-1:0]  fcRow, fcCol, dcIn;
  logic [KW-1:0]  dcTap;
  logic [OW-1:0]  pwN, dcPos;
  logic [PPW-1:0] posP1;
  logic           posOk;
  logic signed [DW-1:0]   opA, opB, fcVal;
  logic signed [ACCW-1:0] prod, accNext, dcBias, pwBias;

  assign fcRow  = ctrl.idx[IW+IW-1:IW];
  assign fcCol  = ctrl.idx[IW-1:0];
  assign dcIn   = ctrl.idx[IW+KW-1:KW];
  assign dcTap  = ctrl.idx[KW-1:0];
  assign pwN    = ctrl.idx[OW-1:0];
  assign posP1  = PPW'({dcIn, 1'b0}) + PPW'(dcTap);
  assign posOk  = (posP1 >= PPW'(1)) && (posP1 <= PPW'(NOUT));
  assign dcPos  = OW'(posP1 - PPW'(1));
  assign dcBias = ACCW'(DC_B) <<< FRAC;
  assign pwBias = ACCW'(PW_B) <<< FRAC;

  always_comb begin
    opA = '0;
    opB = '0;
    if (ctrl.fcStep) begin
      opA = lat[fcCol];
      opB = FC_W[{fcRow, fcCol}];
    end else if (ctrl.dcStep) begin
      opA = hid[dcIn];
      opB = DC_W[dcTap];
    end else if (ctrl.pwStep) begin
      opA = rndSat(dacc[pwN]);
      opB = PW_W;
    end
  end

  assign prod    = ACCW'(opA * opB);
  assign accNext = ((fcCol == '0) ? (ACCW'(FC_B[fcRow]) <<< FRAC) : acc) + prod;
  assign fcVal   = rndSat(accNext);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
      for (int e = 0; e < NIN; e++) begin lat[e] <= '0; hid[e] <= '0; end
      for (int n = 0; n < NOUT; n++) begin dacc[n] <= '0; outR[n] <= '0; end
    end else begin
      if (ctrl.capture) begin
        for (int e = 0; e < NIN; e++) lat[e] <= latentIn[e*DW +: DW];
        for (int n = 0; n < NOUT; n++) dacc[n] <= dcBias;
      end
      if (ctrl.fcStep) begin
        acc <= accNext;
        if (fcCol == IW'(NIN - 1)) hid[fcRow] <= fcVal[DW-1] ? '0 : fcVal;
      end
      if (ctrl.dcStep && posOk) dacc[dcPos] <= dacc[dcPos] + prod;
      if (ctrl.pwStep) outR[pwN] <= rndSat(prod + pwBias);
    end
  end

  for (genvar n = 0; n < NOUT; n++) begin : g_pack_out
    assign samplesOut[n*DW +: DW] = outR[n];
  end
  for (genvar e = 0; e < NIN; e++) begin : g_pack_hid
    assign hiddenFlat[e*DW +: DW] = hid[e];
  end
endmodule

// File: rtl/lat2sig_decoder.sv
module lat2sig_decoder import lat2sig_pkg::*; #(
  parameter logic signed [DW-1:0] FC_W [NIN*NIN] = '{
    16'sd256,  16'sd128, -16'sd64,   16'sd32,
   -16'sd128,  16'sd256,  16'sd64,  -16'sd32,
    16'sd64,  -16'sd256,  16'sd192,  16'sd16,
    16'sd512, -16'sd128, -16'sd96,   16'sd256},
  parameter logic signed [DW-1:0] FC_B [NIN]  = '{-16'sd16, -16'sd32, 16'sd0, -16'sd8},
  parameter logic signed [DW-1:0] DC_W [KLEN] = '{16'sd64, 16'sd192, 16'sd192, 16'sd64},
  parameter logic signed [DW-1:0] DC_B        = 16'sd8,
  parameter logic signed [DW-1:0] PW_W        = 16'sd384,
  parameter logic signed [DW-1:0] PW_B        = -16'sd16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [NIN*DW-1:0]  latentIn,
  output logic               busy,
  output logic               done,
  output logic [NOUT*DW-1:0] samplesOut
);
  ctrl_t ctrl;
  logic [NIN*DW-1:0] hiddenFlat;

  lat2sig_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .ctrl(ctrl), .busy(busy), .done(done)
  );

  lat2sig_dp #(
    .FC_W(FC_W), .FC_B(FC_B), .DC_W(DC_W),
    .DC_B(DC_B), .PW_W(PW_W), .PW_B(PW_B)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .latentIn(latentIn),
    .samplesOut(samplesOut), .hiddenFlat(hiddenFlat)
  );
endmodule

// File: rtl/lat2sig_checker.sv
module lat2sig_checker import lat2sig_pkg::*; (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [NOUT*DW-1:0] samplesOut,
  input ctrl_t              ctrlBus,
  input logic [NIN*DW-1:0]  hiddenFlat
);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  p_run_continues_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  p_capture_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBus.capture |-> !busy);

  p_one_phase_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrlBus.capture, ctrlBus.fcStep, ctrlBus.dcStep, ctrlBus.pwStep}));

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(samplesOut));

  always_ff @(posedge clk) begin
    if (rstN) begin
      for (int e = 0; e < NIN; e++)
        p_relu_nonneg_r4: assert (!hiddenFlat[e*DW + DW - 1]);
    end
  end
endmodule

bind lat2sig_decoder lat2sig_checker u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .samplesOut(samplesOut), .ctrlBus(ctrl), .hiddenFlat(hiddenFlat)
);

// File: tb/lat2sig_decoder_tb.sv
module lat2sig_decoder_tb;
  typedef int vec4_t [4];
  typedef int vec8_t [8];

  localparam int FCW [16] = '{256, 128, -64, 32, -128, 256, 64, -32,
                              64, -256, 192, 16, 512, -128, -96, 256};
  localparam int FCB [4]  = '{-16, -32, 0, -8};
  localparam int DCW [4]  = '{64, 192, 192, 64};
  localparam int DCB      = 8;
  localparam int PWW      = 384;
  localparam int PWB      = -16;
  localparam int LATENCY  = 41;

  logic         clk = 0;
  logic         rstN = 0;
  logic         start = 0;
  logic [63:0]  latentIn = '0;
  logic         busy, done;
  logic [127:0] samplesOut;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lat2sig_decoder u_dut (
    .clk(clk), .rstN(rstN), .start(start), .latentIn(latentIn),
    .busy(busy), .done(done), .samplesOut(samplesOut)
  );

  function automatic longint rs(input longint a);
    longint t;
    t = (a + 128) >>> 8;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return t;
  endfunction

  function automatic vec8_t refRun(input vec4_t x);
    longint h [4];
    longint d [8];
    vec8_t y;
    for (int j = 0; j < 4; j++) begin
      longint s;
      s = longint'(FCB[j]) <<< 8;
      for (int i = 0; i < 4; i++) s += longint'(FCW[4*j+i]) * x[i];
      h[j] = rs(s);
      if (h[j] < 0) h[j] = 0;
    end
    for (int n = 0; n < 8; n++) d[n] = longint'(DCB) <<< 8;
    for (int i = 0; i < 4; i++)
      for (int k = 0; k < 4; k++) begin
        int p;
        p = 2*i + k - 1;
        if (p >= 0 && p < 8) d[p] += h[i] * DCW[k];
      end
    for (int n = 0; n < 8; n++)
      y[n] = int'(rs(rs(d[n]) * PWW + (longint'(PWB) <<< 8)));
    return y;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sample(input int n);
    return int'($signed(samplesOut[n*16 +: 16]));
  endfunction

  task automatic setLatent(input vec4_t x);
    for (int i = 0; i < 4; i++) latentIn[i*16 +: 16] = 16'(x[i]);
  endtask

  task automatic runCase(input vec4_t x, input string tag, input bit midStart, output vec8_t got);
    vec8_t exp;
    vec4_t junk;
    int lat;
    exp = refRun(x);
    junk = '{-32768, 32767, 12345, -999};
    @(negedge clk);
    setLatent(x);
    start = 1;
    lat = 0;
    while (1) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = 0;
      if (lat == 1) setLatent(junk); // R2: later input changes ignored
      if (midStart && lat == 10) start = 1; // R9: pulse while busy
      if (done || lat > 200) break;
    end
    check("R8 latency", lat, LATENCY);
    for (int n = 0; n < 8; n++) begin
      got[n] = sample(n);
      check(tag, got[n], exp[n]);
    end
    @(negedge clk);
    check("R8 done single cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    for (int n = 0; n < 8; n++) check("R11 hold when idle", sample(n), got[n]);
  endtask

  initial begin
    vec8_t r0, r1, r2;
    vec4_t v;
    int seedDummy;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 done in reset", int'(done), 0);
    check("R1 samples in reset", int'(samplesOut != '0), 0);
    rstN = 1;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);

    runCase('{0, 0, 0, 0}, "R4 zero latent all-rectified", 0, r0);
    for (int n = 1; n < 8; n++) check("R4 identical samples", r0[n], r0[0]);

    runCase('{256, 0, 0, 0}, "R3 R5 R6 single element", 0, r1);
    runCase('{0, 0, 0, 512}, "R5 last element edge taps", 0, r1);
    runCase('{-640, -300, 200, -100}, "R3 R4 mixed signs", 0, r1);
    runCase('{32767, 32767, 32767, 32767}, "R7 positive clamp", 0, r1);
    runCase('{-32768, -32768, -32768, -32768}, "R7 negative clamp", 0, r1);
    runCase('{32767, -32768, 32767, -32768}, "R7 alternating full scale", 0, r1);
    runCase('{0, 0, 0, 0}, "R10 clear after saturating run", 0, r2);
    for (int n = 0; n < 8; n++) check("R10 repeat equals first run", r2[n], r0[n]);
    runCase('{300, 200, -100, 50}, "R9 start ignored while busy", 1, r1);

    seedDummy = $urandom(32'd2024);
    for (int t = 0; t < 20; t++) begin
      for (int i = 0; i < 4; i++) v[i] = int'($signed(16'($urandom)));
      if (t % 2 == 0) for (int i = 0; i < 4; i++) v[i] = v[i] / 64;
      runCase(v, "R3 R5 R6 R2 random", (t % 5 == 0), r1);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(1_500_000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule